// File: doc/BRIEF.md
# Instruction Field Decoder with Trap Classification

This block turns a 32-bit fixed-format instruction word into control for a simple register machine. It takes the word apart into an opcode, three 5-bit register indices and a 16-bit immediate. It sorts the opcode into one of four classes by ordered opcode ranges. It then produces register-file read selects, a write select with its enable, memory and stack strobes, branch and jump flags, and a sign-extended immediate. The decode is purely combinational and has no clock or state.

The datapath feeds back the two operand values read through the select outputs. The decoder uses them to raise an unaligned-access trap, from the load/store effective address, and a divide-by-zero trap, from the divisor. The opcode values of the 24 operations come from one parameter array. The decoder only requires that the values rise strictly in the defined operation order, so the class boundaries keep that order. Whenever a trap is reported, every state-changing strobe is held low.

Top module: `instr_field_decoder`

## Requirements
- R1: `opcode_o` is instruction bits 31:26. Register field A is bits 25:21, field B is bits 20:16 and field C is bits 15:11. A select output that is not enabled reads 0.
- R2: With the default numbering, `op_class_o` is 0 (register arithmetic) for opcodes below 14, 1 (load/store/move/stack) for 14 to 18, 2 (control flow) for 19 to 22, and 3 (miscellaneous) for 23 and above.
- R3: `imm_o` is bits 15:0 sign-extended to the data width in classes 1 and 2, so 0x8000 and above become negative. In classes 0 and 3 it is 0.
- R4: Opcodes 0 to 6 (add, sub, mul, div, mod, and, or) read B on source 0 and C on source 1 and write A. Opcode 7 (compare) reads A and B and sets `flag_we_o` with no register write. Opcodes 8 to 13 (flag tests) write A and read nothing.
- R5: Load (15) reads A on source 0, writes B and asserts `mem_rd_o`. Store (16) reads A on source 0 and B on source 1 and asserts `mem_wr_o`. The two are never asserted together.
- R6: Move (14) writes A. Push (17) reads A and asserts `push_o`. Pop (18) writes A and asserts `pop_o`.
- R7: Branch-if-zero (19) reads A and asserts `branch_o`. Jump (20), call (21) and return (22) assert `jump_o`. Call also asserts `push_o` and return asserts `pop_o`.
- R8: `dst_we_o` is never asserted when `dst_sel_o` is 0.
- R9: `trap_o` encodes 0 none, 1 unaligned, 2 divide-by-zero, 3 system call, 4 illegal. Opcode 23 gives 3, and at most one code is reported.
- R10: An opcode that matches no operation (24 to 63 by default) gives trap 4 and leaves every select, enable and strobe at 0.
- R11: Divide (3) with `src1_data_i` equal to 0 gives trap 2. Modulo with a zero divisor gives no trap.
- R12: A load or store whose effective address `src0_data_i + imm_o` has bits 1:0 nonzero gives trap 1.
- R13: While `trap_o` is nonzero, `dst_we_o`, `flag_we_o`, `mem_rd_o`, `mem_wr_o`, `push_o` and `pop_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| src0_data_i | input | DATA_W | Value read through source select 0 |
| src1_data_i | input | DATA_W | Value read through source select 1 |
| opcode_o | output | 6 | Extracted opcode |
| op_class_o | output | 2 | Opcode class |
| imm_o | output | DATA_W | Sign-extended immediate or 0 |
| src0_sel_o | output | 5 | Read index, port 0 |
| src0_en_o | output | 1 | Read enable, port 0 |
| src1_sel_o | output | 5 | Read index, port 1 |
| src1_en_o | output | 1 | Read enable, port 1 |
| dst_sel_o | output | 5 | Write index |
| dst_we_o | output | 1 | Register write enable |
| flag_we_o | output | 1 | Compare-flag update |
| mem_rd_o | output | 1 | Memory load strobe |
| mem_wr_o | output | 1 | Memory store strobe |
| push_o | output | 1 | Stack push strobe |
| pop_o | output | 1 | Stack pop strobe |
| branch_o | output | 1 | Conditional branch |
| jump_o | output | 1 | Unconditional transfer |
| trap_o | output | 3 | Trap code |

## Verification
Every output is a combinational function of the present instruction word and the two operand values, so each result is due in the same cycle as its stimulus, with zero register stages. The bench changes the inputs just after a rising clock edge and samples all outputs at the following falling edge. It then compares them against a bench model of the requirements. The trap code and the strobe gating that depends on it are checked in that same sample, because the operand values enter the address adder without a register between.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

   localparam int NUM_OPS = 24;
   localparam int OPC_W   = 6;
   localparam int REG_W   = 5;
   localparam int IMM_W   = 16;

   typedef enum logic [4:0] {
      OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_MOD, OP_AND, OP_OR, OP_CMP,
      OP_EQ, OP_NE, OP_LT, OP_LE, OP_GE, OP_GT,
      OP_MOV, OP_LW, OP_SW, OP_PUSH, OP_POP,
      OP_BEZ, OP_JMP, OP_CALL, OP_RET,
      OP_SYS
   } op_e;

   typedef enum logic [1:0] {
      CLS_ARITH = 2'd0,
      CLS_MEM   = 2'd1,
      CLS_CTRL  = 2'd2,
      CLS_MISC  = 2'd3
   } cls_e;

   typedef enum logic [2:0] {
      TRAP_NONE  = 3'd0,
      TRAP_ALIGN = 3'd1,
      TRAP_DIV0  = 3'd2,
      TRAP_SYS   = 3'd3,
      TRAP_ILL   = 3'd4
   } trap_e;

   typedef logic [NUM_OPS-1:0][OPC_W-1:0] opc_map_t;

   function automatic opc_map_t identity_opc_map();
      opc_map_t m;
      for (int i = 0; i < NUM_OPS; i++) m[i] = OPC_W'(i);
      return m;
   endfunction

   typedef struct packed {
      logic [REG_W-1:0] s0_sel;
      logic             s0_en;
      logic [REG_W-1:0] s1_sel;
      logic             s1_en;
      logic [REG_W-1:0] d_sel;
      logic             d_has;
      logic             flag_we;
      logic             mem_rd;
      logic             mem_wr;
      logic             push;
      logic             pop;
      logic             branch;
      logic             jump;
      logic             is_div;
      logic             is_sys;
      logic             is_ill;
   } ctl_t;

endpackage

// File: rtl/ifd_fields.sv
module ifd_fields
   import ifd_pkg::*;
#(
   parameter int INSTR_W = 32
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic [OPC_W-1:0]   opcode_o,
   output logic [REG_W-1:0]   ra_o,
   output logic [REG_W-1:0]   rb_o,
   output logic [REG_W-1:0]   rc_o,
   output logic [IMM_W-1:0]   imm16_o
);
   localparam int OPC_LSB = INSTR_W - OPC_W;
   localparam int RA_LSB  = OPC_LSB - REG_W;
   localparam int RB_LSB  = RA_LSB - REG_W;
   localparam int RC_LSB  = RB_LSB - REG_W;

   if (INSTR_W != 32) begin : g_bad_w
      $error("ifd_fields: instruction word must be 32 bits");
   end

   assign opcode_o = instr_i[OPC_LSB +: OPC_W];
   assign ra_o     = instr_i[RA_LSB +: REG_W];
   assign rb_o     = instr_i[RB_LSB +: REG_W];
   assign rc_o     = instr_i[RC_LSB +: REG_W];
   assign imm16_o  = instr_i[IMM_W-1:0];
endmodule

// File: rtl/ifd_ctl.sv
module ifd_ctl
   import ifd_pkg::*;
#(
   parameter opc_map_t OPC_MAP = identity_opc_map()
) (
   input  logic [OPC_W-1:0] opcode_i,
   input  logic [REG_W-1:0] ra_i,
   input  logic [REG_W-1:0] rb_i,
   input  logic [REG_W-1:0] rc_i,
   output cls_e             cls_o,
   output ctl_t             ctl_o
);
   for (genvar g = 1; g < NUM_OPS; g++) begin : g_order
      if (OPC_MAP[g] <= OPC_MAP[g-1]) begin : g_bad
         $error("ifd_ctl: opcode map must rise strictly in operation order");
      end
   end

   logic hit;
   op_e  idx;

   always_comb begin
      hit = 1'b0;
      idx = OP_ADD;
      for (int i = 0; i < NUM_OPS; i++) begin
         if (opcode_i == OPC_MAP[i]) begin
            hit = 1'b1;
            idx = op_e'(i[4:0]);
         end
      end
   end

   always_comb begin
      if (opcode_i < OPC_MAP[OP_MOV])      cls_o = CLS_ARITH;
      else if (opcode_i < OPC_MAP[OP_BEZ]) cls_o = CLS_MEM;
      else if (opcode_i < OPC_MAP[OP_SYS]) cls_o = CLS_CTRL;
      else                                 cls_o = CLS_MISC;
   end

   always_comb begin
      ctl_o = '0;
      if (!hit) begin
         ctl_o.is_ill = 1'b1;
      end else begin
         unique case (idx)
            OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_MOD, OP_AND, OP_OR: begin
               ctl_o.s0_sel = rb_i; ctl_o.s0_en = 1'b1;
               ctl_o.s1_sel = rc_i; ctl_o.s1_en = 1'b1;
               ctl_o.d_sel  = ra_i; ctl_o.d_has = 1'b1;
               ctl_o.is_div = (idx == OP_DIV);
            end
            OP_CMP: begin
               ctl_o.s0_sel = ra_i; ctl_o.s0_en = 1'b1;
               ctl_o.s1_sel = rb_i; ctl_o.s1_en = 1'b1;
               ctl_o.flag_we = 1'b1;
            end
            OP_EQ, OP_NE, OP_LT, OP_LE, OP_GE, OP_GT, OP_MOV: begin
               ctl_o.d_sel = ra_i; ctl_o.d_has = 1'b1;
            end
            OP_LW: begin
               ctl_o.s0_sel = ra_i; ctl_o.s0_en = 1'b1;
               ctl_o.d_sel  = rb_i; ctl_o.d_has = 1'b1;
               ctl_o.mem_rd = 1'b1;
            end
            OP_SW: begin
               ctl_o.s0_sel = ra_i; ctl_o.s0_en = 1'b1;
               ctl_o.s1_sel = rb_i; ctl_o.s1_en = 1'b1;
               ctl_o.mem_wr = 1'b1;
            end
            OP_PUSH: begin
               ctl_o.s0_sel = ra_i; ctl_o.s0_en = 1'b1;
               ctl_o.push   = 1'b1;
            end
            OP_POP: begin
               ctl_o.d_sel = ra_i; ctl_o.d_has = 1'b1;
               ctl_o.pop   = 1'b1;
            end
            OP_BEZ: begin
               ctl_o.s0_sel = ra_i; ctl_o.s0_en = 1'b1;
               ctl_o.branch = 1'b1;
            end
            OP_JMP:  ctl_o.jump = 1'b1;
            OP_CALL: begin ctl_o.jump = 1'b1; ctl_o.push = 1'b1; end
            OP_RET:  begin ctl_o.jump = 1'b1; ctl_o.pop  = 1'b1; end
            OP_SYS:  ctl_o.is_sys = 1'b1;
            default: ctl_o.is_ill = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/ifd_trap.sv
module ifd_trap
   import ifd_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ALIGN_BITS = 2
) (
   input  logic              is_ill_i,
   input  logic              is_sys_i,
   input  logic              is_div_i,
   input  logic              mem_op_i,
   input  logic [DATA_W-1:0] src0_data_i,
   input  logic [DATA_W-1:0] src1_data_i,
   input  logic [DATA_W-1:0] imm_i,
   output trap_e             trap_o
);
   if (ALIGN_BITS < 0 || ALIGN_BITS > 4) begin : g_bad_align
      $error("ifd_trap: ALIGN_BITS out of range");
   end

   logic misaligned;

   if (ALIGN_BITS > 0) begin : g_align
      logic [ALIGN_BITS-1:0] ea_low;
      assign ea_low     = src0_data_i[ALIGN_BITS-1:0] + imm_i[ALIGN_BITS-1:0];
      assign misaligned = mem_op_i && (ea_low != '0);
   end else begin : g_no_align
      assign misaligned = 1'b0;
   end

   logic div_zero;
   assign div_zero = is_div_i && (src1_data_i == '0);

   always_comb begin
      if (is_ill_i)        trap_o = TRAP_ILL;
      else if (is_sys_i)   trap_o = TRAP_SYS;
      else if (div_zero)   trap_o = TRAP_DIV0;
      else if (misaligned) trap_o = TRAP_ALIGN;
      else                 trap_o = TRAP_NONE;
   end
endmodule

// File: rtl/instr_field_decoder.sv
module instr_field_decoder
   import ifd_pkg::*;
#(
   parameter int       DATA_W     = 32,
   parameter int       ALIGN_BITS = 2,
   parameter opc_map_t OPC_MAP    = identity_opc_map()
) (
   input  logic [31:0]       instr_i,
   input  logic [DATA_W-1:0] src0_data_i,
   input  logic [DATA_W-1:0] src1_data_i,
   output logic [5:0]        opcode_o,
   output logic [1:0]        op_class_o,
   output logic [DATA_W-1:0] imm_o,
   output logic [4:0]        src0_sel_o,
   output logic              src0_en_o,
   output logic [4:0]        src1_sel_o,
   output logic              src1_en_o,
   output logic [4:0]        dst_sel_o,
   output logic              dst_we_o,
   output logic              flag_we_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic              push_o,
   output logic              pop_o,
   output logic              branch_o,
   output logic              jump_o,
   output logic [2:0]        trap_o
);
   localparam int EXT_W = DATA_W - IMM_W;

   if (DATA_W < IMM_W) begin : g_bad_dw
      $error("instr_field_decoder: DATA_W must hold the immediate");
   end

   logic [OPC_W-1:0] opc;
   logic [REG_W-1:0] ra, rb, rc;
   logic [IMM_W-1:0] imm16;
   cls_e             cls;
   ctl_t             ctl;
   trap_e            trap;
   logic [DATA_W-1:0] imm_ext;
   logic             quiet;

   ifd_fields #(.INSTR_W(32)) u_fields (
      .instr_i (instr_i),
      .opcode_o(opc),
      .ra_o    (ra),
      .rb_o    (rb),
      .rc_o    (rc),
      .imm16_o (imm16)
   );

   ifd_ctl #(.OPC_MAP(OPC_MAP)) u_ctl (
      .opcode_i(opc),
      .ra_i    (ra),
      .rb_i    (rb),
      .rc_i    (rc),
      .cls_o   (cls),
      .ctl_o   (ctl)
   );

   always_comb begin
      if (cls == CLS_MEM || cls == CLS_CTRL)
         imm_ext = {{EXT_W{imm16[IMM_W-1]}}, imm16};
      else
         imm_ext = '0;
   end

   ifd_trap #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_trap (
      .is_ill_i   (ctl.is_ill),
      .is_sys_i   (ctl.is_sys),
      .is_div_i   (ctl.is_div),
      .mem_op_i   (ctl.mem_rd | ctl.mem_wr),
      .src0_data_i(src0_data_i),
      .src1_data_i(src1_data_i),
      .imm_i      (imm_ext),
      .trap_o     (trap)
   );

   assign quiet = (trap == TRAP_NONE);

   assign opcode_o   = opc;
   assign op_class_o = cls;
   assign imm_o      = imm_ext;
   assign src0_sel_o = ctl.s0_sel;
   assign src0_en_o  = ctl.s0_en;
   assign src1_sel_o = ctl.s1_sel;
   assign src1_en_o  = ctl.s1_en;
   assign dst_sel_o  = ctl.d_sel;
   assign dst_we_o   = ctl.d_has && (ctl.d_sel != '0) && quiet;
   assign flag_we_o  = ctl.flag_we && quiet;
   assign mem_rd_o   = ctl.mem_rd && quiet;
   assign mem_wr_o   = ctl.mem_wr && quiet;
   assign push_o     = ctl.push && quiet;
   assign pop_o      = ctl.pop && quiet;
   assign branch_o   = ctl.branch;
   assign jump_o     = ctl.jump;
   assign trap_o     = trap;
endmodule

// File: rtl/ifd_checker.sv
module ifd_checker #(
   parameter int DATA_W = 32
) (
   input logic [31:0]       instr_i,
   input logic [DATA_W-1:0] src1_data_i,
   input logic              src0_en_o,
   input logic              src1_en_o,
   input logic [4:0]        dst_sel_o,
   input logic              dst_we_o,
   input logic              flag_we_o,
   input logic              mem_rd_o,
   input logic              mem_wr_o,
   input logic              push_o,
   input logic              pop_o,
   input logic [2:0]        trap_o
);
   always_comb begin
      if (!$isunknown(instr_i)) begin
         assert_no_zero_write_R8: assert (!(dst_we_o && dst_sel_o == 5'd0))
            else $error("write enable on index 0");
         assert_trap_range_R9: assert (trap_o <= 3'd4)
            else $error("trap code out of range");
         assert_mem_excl_R5: assert (!(mem_rd_o && mem_wr_o))
            else $error("load and store together");
         assert_trap_quiet_R13: assert (trap_o == 3'd0 ||
               !(dst_we_o || flag_we_o || mem_rd_o || mem_wr_o || push_o || pop_o))
            else $error("strobe during trap");
         assert_illegal_noread_R10: assert (trap_o != 3'd4 || !(src0_en_o || src1_en_o))
            else $error("read enable on illegal opcode");
         assert_div0_cause_R11: assert (trap_o != 3'd2 || src1_data_i == '0)
            else $error("divide trap with nonzero divisor");
      end
   end
endmodule

bind instr_field_decoder ifd_checker #(.DATA_W(DATA_W)) u_ifd_checker (
   .instr_i    (instr_i),
   .src1_data_i(src1_data_i),
   .src0_en_o  (src0_en_o),
   .src1_en_o  (src1_en_o),
   .dst_sel_o  (dst_sel_o),
   .dst_we_o   (dst_we_o),
   .flag_we_o  (flag_we_o),
   .mem_rd_o   (mem_rd_o),
   .mem_wr_o   (mem_wr_o),
   .push_o     (push_o),
   .pop_o      (pop_o),
   .trap_o     (trap_o)
);

// File: tb/tb_instr_field_decoder.sv
module tb_instr_field_decoder;
   localparam int DW = 32;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [31:0]   instr;
   logic [DW-1:0] d0, d1;
   logic [5:0]    opcode_o;
   logic [1:0]    op_class_o;
   logic [DW-1:0] imm_o;
   logic [4:0]    src0_sel_o, src1_sel_o, dst_sel_o;
   logic          src0_en_o, src1_en_o, dst_we_o, flag_we_o;
   logic          mem_rd_o, mem_wr_o, push_o, pop_o, branch_o, jump_o;
   logic [2:0]    trap_o;

   instr_field_decoder dut (
      .instr_i(instr), .src0_data_i(d0), .src1_data_i(d1),
      .opcode_o(opcode_o), .op_class_o(op_class_o), .imm_o(imm_o),
      .src0_sel_o(src0_sel_o), .src0_en_o(src0_en_o),
      .src1_sel_o(src1_sel_o), .src1_en_o(src1_en_o),
      .dst_sel_o(dst_sel_o), .dst_we_o(dst_we_o), .flag_we_o(flag_we_o),
      .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .push_o(push_o), .pop_o(pop_o),
      .branch_o(branch_o), .jump_o(jump_o), .trap_o(trap_o)
   );

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h instr=%h", tag, act, exp, instr);
      end
   endtask

   function automatic logic [31:0] mk(int op, int a, int b, int imm);
      return {6'(op), 5'(a), 5'(b), 16'(imm)};
   endfunction

   // Bench model of R1-R13 evaluated on the present stimulus
   task automatic apply(logic [31:0] w, logic [DW-1:0] v0, logic [DW-1:0] v1);
      int op, a, b, c, cls, trap;
      logic [DW-1:0] imm;
      logic [4:0] s0, s1, ds;
      logic e0, e1, has, fl, mr, mw, pu, po, br, jp;
      string stag;
      @(posedge clk);
      #1;
      instr = w; d0 = v0; d1 = v1;
      op = int'(w[31:26]); a = int'(w[25:21]); b = int'(w[20:16]); c = int'(w[15:11]);
      cls = (op < 14) ? 0 : (op < 19) ? 1 : (op < 23) ? 2 : 3;
      imm = (cls == 1 || cls == 2) ? {{16{w[15]}}, w[15:0]} : '0;
      s0 = 0; s1 = 0; ds = 0; e0 = 0; e1 = 0; has = 0;
      fl = 0; mr = 0; mw = 0; pu = 0; po = 0; br = 0; jp = 0; trap = 0;
      if (op <= 6) begin s0 = 5'(b); e0 = 1; s1 = 5'(c); e1 = 1; ds = 5'(a); has = 1; end
      else if (op == 7) begin s0 = 5'(a); e0 = 1; s1 = 5'(b); e1 = 1; fl = 1; end
      else if (op <= 14) begin ds = 5'(a); has = 1; end
      else if (op == 15) begin s0 = 5'(a); e0 = 1; ds = 5'(b); has = 1; mr = 1; end
      else if (op == 16) begin s0 = 5'(a); e0 = 1; s1 = 5'(b); e1 = 1; mw = 1; end
      else if (op == 17) begin s0 = 5'(a); e0 = 1; pu = 1; end
      else if (op == 18) begin ds = 5'(a); has = 1; po = 1; end
      else if (op == 19) begin s0 = 5'(a); e0 = 1; br = 1; end
      else if (op == 20) jp = 1;
      else if (op == 21) begin jp = 1; pu = 1; end
      else if (op == 22) begin jp = 1; po = 1; end
      else if (op == 23) trap = 3;
      else trap = 4;
      if (op == 3 && v1 == 0) trap = 2;
      if ((op == 15 || op == 16) && ((v0 + imm) & 32'h3) != 0) trap = 1;
      if (trap != 0) begin fl = 0; mr = 0; mw = 0; pu = 0; po = 0; end
      if (trap != 0) stag = "R13";
      else if (cls == 0) stag = "R4";
      else if (op == 15 || op == 16) stag = "R5";
      else if (cls == 1) stag = "R6";
      else stag = "R7";
      if (op >= 24) stag = "R10";
      @(negedge clk);
      check("R1 fields", {opcode_o, src0_sel_o, src1_sel_o, dst_sel_o},
            {6'(op), s0, s1, ds});
      check("R2 class", 64'(op_class_o), 64'(cls));
      check("R3 immediate", 64'(imm_o), 64'(imm));
      check({stag, " strobes"},
            {src0_en_o, src1_en_o, flag_we_o, mem_rd_o, mem_wr_o, push_o, pop_o, branch_o, jump_o},
            {e0, e1, fl, mr, mw, pu, po, br, jp});
      check("R8 write enable", 64'(dst_we_o), 64'(has && ds != 0 && trap == 0));
      case (trap)
         1: check("R12 trap", 64'(trap_o), 64'(trap));
         2: check("R11 trap", 64'(trap_o), 64'(trap));
         4: check("R10 trap", 64'(trap_o), 64'(trap));
         default: check("R9 trap", 64'(trap_o), 64'(trap));
      endcase
   endtask

   initial begin
      void'($urandom(32'd1234));
      instr = '0; d0 = '0; d1 = '0;
      // Idle word: add into r0 must not write (R8)
      apply(32'h0, 32'h0, 32'h0);
      // Every opcode once with fixed fields, aligned operands (R2, R4-R7, R9, R10)
      for (int op = 0; op < 64; op++) apply(mk(op, 3, 7, 16'h2800 | 16'h0004), 32'h100, 32'h5);
      // Sign extension boundary (R3)
      apply(mk(14, 4, 0, 16'h8000), 0, 0);
      apply(mk(14, 4, 0, 16'h7FFF), 0, 0);
      apply(mk(20, 0, 0, 16'hFFFF), 0, 0);
      // Alignment (R12) and load/store register roles (R5)
      apply(mk(15, 2, 9, 16'h0004), 32'h1000, 0);
      apply(mk(15, 2, 9, 16'h0001), 32'h1000, 0);
      apply(mk(16, 2, 9, 16'hFFFE), 32'h1000, 0);
      apply(mk(16, 2, 9, 16'hFFFD), 32'h1003, 0);
      // Divide and modulo by zero (R11, R13)
      apply(mk(3, 5, 6, 7 << 11), 32'd10, 32'd0);
      apply(mk(4, 5, 6, 7 << 11), 32'd10, 32'd0);
      // Writes to index 0 by move, pop, load (R8)
      apply(mk(14, 0, 0, 16'h1234), 0, 0);
      apply(mk(18, 0, 0, 0), 0, 0);
      apply(mk(15, 1, 0, 0), 32'h40, 0);
      // Random mix
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] w, x0, x1;
         w = $urandom; x0 = $urandom; x1 = $urandom;
         if (($urandom % 4) == 0) x1 = 0;
         if (($urandom % 2) == 0) w[31:26] = 6'($urandom % 24);
         apply(w, x0, x1);
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule